// File: doc/BRIEF.md
# I/O Halt Instruction Response Unit

This unit carries out the halt-device I/O instruction on the processor side. When a decoded instruction word is presented with a start strobe, the unit checks that the word is the halt form of the shared I/O opcode. It checks the odd byte parity of the word, then sends a halt request carrying the 14-bit device address to a device controller over a simple request/response channel. The controller stops the addressed device at once and clears any interrupt it has pending. The controller answers with an accept flag, a busy flag and two 32-bit status words, each protected by odd parity.

The unit turns the answer into a 4-bit condition code and writes none, one or two general registers through a single register-file write port. The register field of the instruction selects the count. A field of zero writes nothing. An odd field writes one word. An even, nonzero field writes two words, to R+1 and then to R. A missing answer is bounded by a timeout. Every accepted instruction ends with a one-cycle done pulse.

Instruction bit numbering is most-significant-first in the instruction set, so instruction bit n is `instr[31-n]`. The opcode is `instr[30:24]`, the register field is `instr[23:20]`, the extension is `instr[16:14]` and the device address is `instr[13:0]`.

Top module: `hio_unit`

## Requirements
- R1: A start is acted on only when `instr[30:24]` equals 7'h4F and `instr[16:14]` equals 3'b000. Any other word is ignored: no request, no done pulse, and `cc` keeps its value.
- R2: While `req_valid` is high, `req_addr` equals `instr[13:0]` of the accepted instruction and stays stable until a response is taken or the wait times out.
- R3: `instr_par[i]` gives odd parity over `instr[8i+7:8i]`. If any byte fails, `cc` becomes 4'b1110, no request is issued, no register is written, and `done` pulses in the cycle after the start edge.
- R4: A response with `rsp_ack`=1 and `rsp_busy`=0 gives `cc` 4'b0000, and one with `rsp_ack`=1 and `rsp_busy`=1 gives 4'b0100. Register writes happen only for these two codes.
- R5: A response with `rsp_ack`=0 gives `cc` 4'b1100 and no register writes.
- R6: If no response arrives within TIMEOUT cycles of the request, the request is dropped, `cc` becomes 4'b1100, no register is written, and `done` pulses TIMEOUT+1 cycles after the start edge.
- R7: `rsp_flag_par` is odd parity over {`rsp_ack`,`rsp_busy`}, and `rsp_par[i]` is odd parity over `rsp_data[8i+7:8i]`; data parity is checked only when `rsp_ack`=1. Any failure gives `cc` 4'b0010 with no register writes.
- R8: A register field of 0 writes no register. `done` pulses in the cycle after the response edge.
- R9: An odd register field R writes `rsp_data[31:0]` to register R in the cycle after the response edge, and `done` follows one cycle later.
- R10: An even, nonzero register field R writes `rsp_data[31:0]` to R+1 and then `rsp_data[63:32]` to R, in the two cycles after the response edge, and `done` follows one cycle later.
- R11: `done` is high for exactly one cycle. `cc` carries the final code while `done` is high and holds it until the next instruction completes.
- R12: A start received while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction present strobe |
| instr | input | 32 | Instruction word |
| instr_par | input | 4 | Odd parity, one bit per instruction byte |
| req_valid | output | 1 | Halt request to device controller |
| req_addr | output | 14 | Device address of the request |
| rsp_valid | input | 1 | Controller response strobe |
| rsp_ack | input | 1 | Address recognized, halt accepted |
| rsp_busy | input | 1 | Controller was busy at the halt |
| rsp_flag_par | input | 1 | Odd parity over ack and busy |
| rsp_data | input | 64 | Status words: [31:0] first, [63:32] second |
| rsp_par | input | 8 | Odd parity, one bit per status byte |
| rf_we | output | 1 | General register write enable |
| rf_waddr | output | 4 | General register number |
| rf_wdata | output | 32 | General register write data |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 4 | Condition code |

## Verification
Every result has a fixed cycle count measured from the edge that takes the start. The request is visible one cycle after that edge, and a bad-parity instruction finishes one cycle after it. After the response edge, `done` comes one cycle later when there are no writes, two cycles later with one write and three cycles later with two writes. A timeout finishes TIMEOUT+1 cycles after the start edge. The bench drives and samples on falling edges. For each scenario it counts those edges from the start, works out the expected latency, addresses and data from the requirements, and compares them with what it sees. It also confirms that `done` falls on the next sample.

// File: rtl/hio_pkg.sv
// Shared constants, state type and parity helper for the halt unit.
// Assumes odd parity: a byte plus its parity bit holds an odd number of ones.
package hio_pkg;
    localparam logic [6:0] OPC_IO    = 7'h4F;
    localparam logic [2:0] EXT_HALT  = 3'b000;
    localparam logic [3:0] CC_OK     = 4'b0000;
    localparam logic [3:0] CC_BUSY   = 4'b0100;
    localparam logic [3:0] CC_RPAR   = 4'b0010;
    localparam logic [3:0] CC_NOADDR = 4'b1100;
    localparam logic [3:0] CC_IPAR   = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_WR_HI,
        ST_WR_R,
        ST_FIN
    } hio_state_e;

    // True when the bits and their parity bit hold an odd count of ones.
    function automatic logic odd_ok2(input logic [1:0] bits, input logic p);
        return ^{bits, p};
    endfunction
endpackage

// File: rtl/hio_oddpar.sv
// Checks odd parity over BYTES bytes, one parity bit per byte.
// Assumes par[i] covers data[8i+7:8i]. Purely combinational.
module hio_oddpar #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] data,
    input  logic [BYTES-1:0]   par,
    output logic               ok
);
    logic [BYTES-1:0] byte_ok;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // One byte plus its parity bit must hold an odd number of ones.
        assign byte_ok[i] = ^{data[8*i +: 8], par[i]};
    end

    // All bytes must pass.
    assign ok = &byte_ok;
endmodule

// File: rtl/hio_decode.sv
// Decodes an instruction word for the halt form of the shared I/O opcode.
// Assumes bit n of the instruction set is instr[31-n]; indirect and
// unused bits are not examined.
module hio_decode
    import hio_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int RF_W   = 4
) (
    input  logic [31:0]       instr,
    input  logic [3:0]        instr_par,
    output logic              is_halt,
    output logic              ipar_ok,
    output logic [RF_W-1:0]   rfield,
    output logic [ADDR_W-1:0] addr
);
    logic unused_bits;

    // Opcode and extension both must match the halt form.
    assign is_halt = (instr[30:24] == OPC_IO) && (instr[16:14] == EXT_HALT);
    // Field extraction.
    assign rfield  = instr[23:20];
    assign addr    = instr[ADDR_W-1:0];
    assign unused_bits = ^{instr[31], instr[19:17]};

    // Byte parity over the incoming word.
    hio_oddpar #(.BYTES(4)) u_ipar (
        .data (instr),
        .par  (instr_par),
        .ok   (ipar_ok)
    );
endmodule

// File: rtl/hio_seq.sv
// Sequencer: issues the halt request, waits for the response or timeout,
// forms the condition code and drives the register write port.
// Assumes decode and parity results are valid in the cycle of start.
module hio_seq
    import hio_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int RF_W    = 4,
    parameter int TIMEOUT = 16,
    localparam int TO_W   = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_halt,
    input  logic              ipar_ok,
    input  logic [RF_W-1:0]   rfield,
    input  logic [ADDR_W-1:0] addr,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic              rsp_busy,
    input  logic              rsp_flag_par,
    input  logic [63:0]       rsp_data,
    input  logic              data_ok,
    output logic              rf_we,
    output logic [RF_W-1:0]   rf_waddr,
    output logic [31:0]       rf_wdata,
    output logic              done,
    output logic [3:0]        cc
);
    hio_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RF_W-1:0]   r_q;
    logic [31:0]       w0_q, w1_q;
    logic [3:0]        cc_q;
    logic [TO_W-1:0]   cnt_q;
    logic              flag_ok;

    // Parity of the returned flag pair.
    assign flag_ok = odd_ok2({rsp_ack, rsp_busy}, rsp_flag_par);

    // Main sequence: decode accept, wait, writes, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            r_q     <= '0;
            w0_q    <= '0;
            w1_q    <= '0;
            cc_q    <= CC_OK;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && is_halt) begin
                        if (!ipar_ok) begin
                            cc_q    <= CC_IPAR;
                            state_q <= ST_FIN;
                        end else begin
                            addr_q  <= addr;
                            r_q     <= rfield;
                            cnt_q   <= '0;
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (!flag_ok) begin
                            cc_q    <= CC_RPAR;
                            state_q <= ST_FIN;
                        end else if (!rsp_ack) begin
                            cc_q    <= CC_NOADDR;
                            state_q <= ST_FIN;
                        end else if (!data_ok) begin
                            cc_q    <= CC_RPAR;
                            state_q <= ST_FIN;
                        end else begin
                            cc_q <= rsp_busy ? CC_BUSY : CC_OK;
                            w0_q <= rsp_data[31:0];
                            w1_q <= rsp_data[63:32];
                            if (r_q == '0)
                                state_q <= ST_FIN;
                            else if (r_q[0])
                                state_q <= ST_WR_R;
                            else
                                state_q <= ST_WR_HI;
                        end
                    end else if (cnt_q == TO_W'(TIMEOUT - 1)) begin
                        cc_q    <= CC_NOADDR;
                        state_q <= ST_FIN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WR_HI: state_q <= ST_WR_R;
                ST_WR_R:  state_q <= ST_FIN;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state and held registers.
    always_comb begin
        req_valid = (state_q == ST_WAIT);
        req_addr  = addr_q;
        rf_we     = (state_q == ST_WR_HI) || (state_q == ST_WR_R);
        rf_waddr  = (state_q == ST_WR_HI) ? r_q + 1'b1 : r_q;
        rf_wdata  = ((state_q == ST_WR_R) && !r_q[0]) ? w1_q : w0_q;
        done      = (state_q == ST_FIN);
        cc        = cc_q;
    end

    assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |-> $stable(req_addr));

    assert_ipar_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && is_halt && !ipar_ok) |=> (!req_valid && done && cc == CC_IPAR));

    assert_wr_only_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (cc == CC_OK || cc == CC_BUSY));

    assert_req_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_valid) |-> (done || rf_we));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/hio_unit.sv
// Top of the halt instruction response unit: decode, response parity
// check and sequencer. Assumes one instruction at a time; starts during
// an operation are dropped.
module hio_unit
    import hio_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] instr,
    input  logic [3:0]  instr_par,
    output logic        req_valid,
    output logic [13:0] req_addr,
    input  logic        rsp_valid,
    input  logic        rsp_ack,
    input  logic        rsp_busy,
    input  logic        rsp_flag_par,
    input  logic [63:0] rsp_data,
    input  logic [7:0]  rsp_par,
    output logic        rf_we,
    output logic [3:0]  rf_waddr,
    output logic [31:0] rf_wdata,
    output logic        done,
    output logic [3:0]  cc
);
    localparam int ADDR_W = 14;
    localparam int RF_W   = 4;

    logic              is_halt, ipar_ok, data_ok;
    logic [RF_W-1:0]   rfield;
    logic [ADDR_W-1:0] addr;

    hio_decode #(.ADDR_W(ADDR_W), .RF_W(RF_W)) u_dec (
        .instr     (instr),
        .instr_par (instr_par),
        .is_halt   (is_halt),
        .ipar_ok   (ipar_ok),
        .rfield    (rfield),
        .addr      (addr)
    );

    hio_oddpar #(.BYTES(8)) u_rpar (
        .data (rsp_data),
        .par  (rsp_par),
        .ok   (data_ok)
    );

    hio_seq #(.ADDR_W(ADDR_W), .RF_W(RF_W), .TIMEOUT(TIMEOUT)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .is_halt      (is_halt),
        .ipar_ok      (ipar_ok),
        .rfield       (rfield),
        .addr         (addr),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .rsp_valid    (rsp_valid),
        .rsp_ack      (rsp_ack),
        .rsp_busy     (rsp_busy),
        .rsp_flag_par (rsp_flag_par),
        .rsp_data     (rsp_data),
        .data_ok      (data_ok),
        .rf_we        (rf_we),
        .rf_waddr     (rf_waddr),
        .rf_wdata     (rf_wdata),
        .done         (done),
        .cc           (cc)
    );
endmodule

// File: tb/hio_unit_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module hio_unit_tb;
    localparam int TIMEOUT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  instr_par = '0;
    logic        req_valid;
    logic [13:0] req_addr;
    logic        rsp_valid = 1'b0, rsp_ack = 1'b0, rsp_busy = 1'b0, rsp_flag_par = 1'b0;
    logic [63:0] rsp_data = '0;
    logic [7:0]  rsp_par = '0;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        done;
    logic [3:0]  cc;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    hio_unit #(.TIMEOUT(TIMEOUT)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] opc, input logic [3:0] r,
                                       input logic [2:0] ext, input logic [13:0] a);
        logic [31:0] w = '0;
        w[30:24] = opc; w[23:20] = r; w[16:14] = ext; w[13:0] = a;
        return w;
    endfunction

    function automatic logic [3:0] ipar(input logic [31:0] w);
        for (int i = 0; i < 4; i++) ipar[i] = ~^w[8*i +: 8];
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
                $finish;
            end
        end
    end

    // Run one halt instruction; delay<0 means the controller never answers.
    task automatic run(input string tag, input logic [31:0] ins, input bit bad_ipar,
                       input int delay, input logic ack, input logic busy,
                       input logic [63:0] data, input bit bad_flag, input bit bad_data,
                       input logic [3:0] exp_cc, input bit poke);
        logic [3:0]  r = ins[23:20];
        int          nw_exp = 0, nw = 0, waited = 0, lat = 0, lat_exp;
        logic [3:0]  wa_exp [2];
        logic [31:0] wd_exp [2];
        logic [3:0]  wa [2];
        logic [31:0] wd [2];
        bool_t_dummy: begin end
        if ((exp_cc == 4'b0000 || exp_cc == 4'b0100) && r != 0) begin
            if (r[0]) begin
                nw_exp = 1; wa_exp[0] = r; wd_exp[0] = data[31:0];
            end else begin
                nw_exp = 2; wa_exp[0] = r + 4'd1; wd_exp[0] = data[31:0];
                wa_exp[1] = r; wd_exp[1] = data[63:32];
            end
        end
        lat_exp = bad_ipar ? 1 : (delay < 0) ? TIMEOUT + 1 : 2 + delay + nw_exp;
        @(negedge clk);
        start = 1'b1; instr = ins; instr_par = ipar(ins) ^ (bad_ipar ? 4'b0100 : 4'b0000);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            lat++;
            start = 1'b0; rsp_valid = 1'b0;
            if (poke && k == 0) begin
                start = 1'b1; instr = mk(7'h4F, 4'd2, 3'b000, ~ins[13:0]); instr_par = ipar(instr);
            end
            if (rf_we && nw < 2) begin
                wa[nw] = rf_waddr; wd[nw] = rf_wdata; nw++;
            end
            if (req_valid) begin
                chk(req_addr == ins[13:0], {tag, " R2 req_addr"}, req_addr, ins[13:0]);
                if (delay >= 0 && waited == delay) begin
                    rsp_valid = 1'b1; rsp_ack = ack; rsp_busy = busy; rsp_data = data;
                    rsp_flag_par = ~^{ack, busy} ^ bad_flag;
                    for (int i = 0; i < 8; i++) rsp_par[i] = ~^data[8*i +: 8];
                    if (bad_data) rsp_par[5] = ~rsp_par[5];
                end
                waited++;
            end
            if (done) break;
        end
        chk(done == 1'b1, {tag, " R11 done seen"}, done, 1);
        chk(cc == exp_cc, {tag, " cc"}, cc, exp_cc);
        chk(lat == lat_exp, {tag, " latency"}, lat, lat_exp);
        chk(nw == nw_exp, {tag, " write count"}, nw, nw_exp);
        for (int i = 0; i < nw_exp && i < nw; i++) begin
            chk(wa[i] == wa_exp[i], {tag, " write addr"}, wa[i], wa_exp[i]);
            chk(wd[i] == wd_exp[i], {tag, " write data"}, wd[i], wd_exp[i]);
        end
        @(negedge clk);
        start = 1'b0; rsp_valid = 1'b0;
        chk(!done && !req_valid, {tag, " R11 done single pulse, R12 no restart"}, {done, req_valid}, 0);
        chk(cc == exp_cc, {tag, " R11 cc held"}, cc, exp_cc);
    endtask

    // R1: a non-halt word must leave everything untouched.
    task automatic ignored(input string tag, input logic [31:0] ins);
        logic [3:0] cc_before = cc;
        bit seen = 0;
        @(negedge clk);
        start = 1'b1; instr = ins; instr_par = ipar(ins);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (req_valid || done || rf_we) seen = 1;
            @(negedge clk);
        end
        chk(!seen, {tag, " R1 no activity"}, seen, 0);
        chk(cc == cc_before, {tag, " R1 cc unchanged"}, cc, cc_before);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !req_valid && !rf_we && cc == 4'b0000, "reset state", {done, req_valid, rf_we, cc}, 0);

        run("ok R0 R8 R4", mk(7'h4F, 4'd0, 3'b000, 14'h0123), 0, 0, 1, 0,
            64'h1111_2222_3333_4444, 0, 0, 4'b0000, 0);
        ignored("bad ext", mk(7'h4F, 4'd5, 3'b001, 14'h0042));
        ignored("bad opcode", mk(7'h4E, 4'd5, 3'b000, 14'h0042));
        run("busy odd R9 R4", mk(7'h4F, 4'd5, 3'b000, 14'h2A5A), 0, 2, 1, 1,
            64'hDEAD_BEEF_0BAD_F00D, 0, 0, 4'b0100, 0);
        run("even R10", mk(7'h4F, 4'd6, 3'b000, 14'h1F0F), 0, 1, 1, 0,
            64'hCAFE_0001_0000_0123, 0, 0, 4'b0000, 0);
        run("even top R10", mk(7'h4F, 4'd14, 3'b000, 14'h3FFF), 0, 0, 1, 1,
            64'h8000_0000_0000_0001, 0, 0, 4'b0100, 0);
        run("odd top R9", mk(7'h4F, 4'd15, 3'b000, 14'h0001), 0, 0, 1, 0,
            64'h0F0F_0F0F_F0F0_F0F0, 0, 0, 4'b0000, 0);
        run("noaddr R5", mk(7'h4F, 4'd3, 3'b000, 14'h0777), 0, 0, 0, 0,
            64'h1234_5678_9ABC_DEF0, 0, 0, 4'b1100, 0);
        run("timeout R6", mk(7'h4F, 4'd3, 3'b000, 14'h0555), 0, -1, 1, 0,
            64'h0, 0, 0, 4'b1100, 0);
        run("ipar R3", mk(7'h4F, 4'd6, 3'b000, 14'h0AAA), 1, 0, 1, 0,
            64'h0, 0, 0, 4'b1110, 0);
        run("flag par R7", mk(7'h4F, 4'd5, 3'b000, 14'h0101), 0, 1, 1, 0,
            64'h5555_AAAA_5555_AAAA, 1, 0, 4'b0010, 0);
        run("data par R7", mk(7'h4F, 4'd6, 3'b000, 14'h0202), 0, 0, 1, 1,
            64'h0123_4567_89AB_CDEF, 0, 1, 4'b0010, 0);
        run("restart ignored R12", mk(7'h4F, 4'd1, 3'b000, 14'h1234), 0, 3, 1, 0,
            64'h7777_7777_2468_ACE0, 0, 0, 4'b0000, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule